// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Generator

This block turns a single 32-bit trigger word, written by one of the CPUs of a multiprocessor cluster, into per-CPU pending flags for the sixteen software interrupt numbers. The word carries a destination mode, a CPU bitmask and an interrupt number. The block combines the mode with the index of the CPU that wrote the word to find the set of receiving CPUs. It then sets, in one clock, the pending flag of that interrupt number for each receiver.

Every CPU keeps its own copy of each flag. A CPU acknowledges one interrupt number on the clear port, and that removes only its own copy. Copies held by other CPUs are not affected. A trigger that lands in the same cycle as the clear of the same flag wins. A trigger for a flag that is already set leaves a single pending flag; triggers are not counted.

Trigger words enter on a valid/ready channel. The block never applies back-pressure: `trig_ready` is held high at all times, and a word is taken on every rising clock edge where `trig_valid` is high. The sender may therefore treat each cycle with `trig_valid` high as one accepted write. The acknowledge port is a plain strobe with no handshake.

Top module: `ipi_raise`

## Requirements
- R1: While `rst_n` is low, every bit of `pend` is 0. `trig_ready` is 1 in all cycles.
- R2: Fields of the trigger word: the destination mode is in bits 25:24, the CPU bitmask in bits 23:16 and the interrupt number in bits 3:0. Bits 31:26 and 15:4 have no effect.
- R3: Mode 0 sets the flag in the row of every CPU whose bit is set in the bitmask. The flag for CPU c and number n is `pend[c*16+n]`.
- R4: Mode 1 sets the flag for every CPU except the writer `trig_cpu`. The bitmask is ignored.
- R5: Mode 2 sets the flag only for the writer `trig_cpu`. The bitmask is ignored.
- R6: Mode 3 sets no flag.
- R7: In mode 0, bitmask bits at or above NUM_CPU (4 by default) select nothing.
- R8: A pulse on `ack_valid` with `ack_cpu`=c and `ack_id`=n clears `pend[c*16+n]` one cycle later. No other flag changes.
- R9: If a trigger sets a flag in the same cycle as that flag is acknowledged, the flag is 1 afterwards.
- R10: A trigger for a flag that is already set leaves it set as one flag. A single acknowledge then clears it.
- R11: A cycle with `trig_valid` low sets no flag, whatever `trig_word` holds.
- R12: Flags change only on the rising clock edge after the trigger or acknowledge is presented. The update has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_valid | input | 1 | Trigger word present |
| trig_ready | output | 1 | Trigger accepted; always 1 |
| trig_word | input | 32 | Trigger word: mode, bitmask, interrupt number |
| trig_cpu | input | CPU_W (2) | Index of the CPU writing the trigger |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W (2) | CPU whose flag is cleared |
| ack_id | input | 4 | Interrupt number being cleared |
| pend | output | NUM_CPU*16 (64) | Pending flags; bit c*16+n is CPU c, number n |

## Verification
A wrong decoder shows up on `pend` one cycle after the trigger, as a flag in the wrong CPU row or under the wrong number. A flipped self/others choice lands the flag in the writer's own row. A stale or sticky flag inside one row persists in `pend` until it is acknowledged, so it is seen on the very next sample after an acknowledge that should have cleared it. A reversed set/clear priority shows as a missing flag in the cycle right after a colliding trigger and acknowledge.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ID_W     = 4;
  localparam int NUM_ID   = 1 << ID_W;
  localparam int WORD_W   = 32;
  localparam int MODE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int MASK_W   = 8;

  typedef enum logic [1:0] {
    DEST_LIST   = 2'd0,
    DEST_OTHERS = 2'd1,
    DEST_SELF   = 2'd2,
    DEST_RSVD   = 2'd3
  } dest_mode_e;

  typedef struct packed {
    dest_mode_e          mode;
    logic [MASK_W-1:0]   mask;
    logic [ID_W-1:0]     id;
  } trig_fields_t;

  function automatic trig_fields_t split_word(input logic [WORD_W-1:0] w);
    trig_fields_t f;
    f.mode = dest_mode_e'(w[MODE_LSB +: 2]);
    f.mask = w[MASK_LSB +: MASK_W];
    f.id   = w[ID_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/ipi_word_decode.sv
module ipi_word_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic [NUM_CPU-1:0] targets,
  output logic [ID_W-1:0]   id
);
  trig_fields_t fld;
  logic unused_word;

  assign fld         = split_word(word);
  assign id          = fld.id;
  assign unused_word = ^word;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_tgt
    logic is_self;
    assign is_self = (req_cpu == CPU_W'(c));
    always_comb begin
      targets[c] = 1'b0;
      if (valid) begin
        unique case (fld.mode)
          DEST_LIST:   targets[c] = fld.mask[c];
          DEST_OTHERS: targets[c] = !is_self;
          DEST_SELF:   targets[c] = is_self;
          default:     targets[c] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_pend_row.sv
module ipi_pend_row
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ID_W-1:0]   set_id,
  input  logic              clr_en,
  input  logic [ID_W-1:0]   clr_id,
  output logic [NUM_ID-1:0] row
);
  logic [NUM_ID-1:0] set_vec, clr_vec, row_nxt;

  always_comb begin
    set_vec = set_en ? (NUM_ID'(1) << set_id) : '0;
    clr_vec = clr_en ? (NUM_ID'(1) << clr_id) : '0;
    row_nxt = (row & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else        row <= row_nxt;
  end
endmodule

// File: rtl/ipi_raise.sv
module ipi_raise
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig_valid,
  output logic                      trig_ready,
  input  logic [31:0]               trig_word,
  input  logic [CPU_W-1:0]          trig_cpu,
  input  logic                      ack_valid,
  input  logic [CPU_W-1:0]          ack_cpu,
  input  logic [3:0]                ack_id,
  output logic [NUM_CPU*NUM_ID-1:0] pend
);
  logic [NUM_CPU-1:0] targets;
  logic [ID_W-1:0]    tgt_id;

  assign trig_ready = 1'b1;

  ipi_word_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
    .valid   (trig_valid),
    .word    (trig_word),
    .req_cpu (trig_cpu),
    .targets (targets),
    .id      (tgt_id)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_row
    logic clr_here;
    assign clr_here = ack_valid && (ack_cpu == CPU_W'(c));
    ipi_pend_row u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (targets[c]),
      .set_id (tgt_id),
      .clr_en (clr_here),
      .clr_id (ack_id),
      .row    (pend[c*NUM_ID +: NUM_ID])
    );
  end
endmodule

// File: rtl/ipi_raise_chk.sv
module ipi_raise_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      trig_valid,
  input logic                      trig_ready,
  input logic [31:0]               trig_word,
  input logic [CPU_W-1:0]          trig_cpu,
  input logic                      ack_valid,
  input logic [CPU_W-1:0]          ack_cpu,
  input logic [3:0]                ack_id,
  input logic [NUM_CPU*NUM_ID-1:0] pend
);
  logic [1:0] mode_in;
  logic       unused_bits;
  assign mode_in     = trig_word[25:24];
  assign unused_bits = ^trig_word;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> pend == '0);

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) trig_ready);

  // R5
  self_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && mode_in == 2'd2 |=> pend[$past({trig_cpu, trig_word[3:0]})]);

  // R4
  others_skip_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && mode_in == 2'd1 && !ack_valid
    |=> pend[$past({trig_cpu, trig_word[3:0]})] == $past(pend[{trig_cpu, trig_word[3:0]}]));

  // R6
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && mode_in == 2'd3 |=> (pend & ~$past(pend)) == '0);

  // R7
  high_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && mode_in == 2'd0 && trig_word[16 +: NUM_CPU] == '0
    |=> (pend & ~$past(pend)) == '0);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_valid |=> (pend & ~$past(pend)) == '0);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !trig_valid |=> !pend[$past({ack_cpu, ack_id})]);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && mode_in == 2'd2 && ack_valid && ack_cpu == trig_cpu && ack_id == trig_word[3:0]
    |=> pend[$past({ack_cpu, ack_id})]);
endmodule

bind ipi_raise ipi_raise_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_valid (trig_valid),
  .trig_ready (trig_ready),
  .trig_word  (trig_word),
  .trig_cpu   (trig_cpu),
  .ack_valid  (ack_valid),
  .ack_cpu    (ack_cpu),
  .ack_id     (ack_id),
  .pend       (pend)
);

// File: tb/ipi_raise_bench.sv
`timescale 1ns/1ps
module ipi_raise_bench;
  localparam int NCPU = 4;
  localparam int CW   = 2;
  localparam int PW   = NCPU * 16;
  localparam int NVEC = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_valid = 1'b0;
  logic          trig_ready;
  logic [31:0]   trig_word = '0;
  logic [CW-1:0] trig_cpu = '0;
  logic          ack_valid = 1'b0;
  logic [CW-1:0] ack_cpu = '0;
  logic [3:0]    ack_id = '0;
  logic [PW-1:0] pend;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ipi_raise #(.NUM_CPU(NCPU)) u_ipi_raise (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_word(trig_word), .trig_cpu(trig_cpu), .ack_valid(ack_valid),
    .ack_cpu(ack_cpu), .ack_id(ack_id), .pend(pend)
  );

  // Vector table: writer, word, expected pend (bit c*16+n) starting from empty.
  localparam logic [CW-1:0] V_CPU [NVEC] = '{2'd0, 2'd1, 2'd3, 2'd2, 2'd0, 2'd2, 2'd1, 2'd0, 2'd3};
  localparam logic [31:0] V_WORD [NVEC] = '{
    32'h0005_0003,  // R3 mask cpus 0,2 id 3
    32'h01FF_0007,  // R4 others of 1, id 7
    32'h020F_000F,  // R5 self 3, id 15
    32'h03FF_0001,  // R6 reserved
    32'h00F0_0002,  // R7 mask beyond 4 cpus
    32'h001A_0000,  // R3/R7 mask cpus 1,3,4 id 0
    32'hFC02_AB35,  // R2 junk in ignored bits, cpu 1 id 5
    32'h0200_0000,  // R5 self 0, id 0
    32'h0100_000C   // R4 others of 3, id 12
  };
  localparam logic [PW-1:0] V_EXP [NVEC] = '{
    64'h0000_0008_0000_0008,
    64'h0080_0080_0000_0080,
    64'h8000_0000_0000_0000,
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0000,
    64'h0001_0000_0001_0000,
    64'h0000_0000_0020_0000,
    64'h0000_0000_0000_0001,
    64'h0000_1000_1000_1000
  };

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present one cycle of stimulus, sample at the negedge after the capturing edge.
  task automatic step(input logic tv, input logic [CW-1:0] tc, input logic [31:0] tw,
                      input logic av, input logic [CW-1:0] ac, input logic [3:0] ai);
    trig_valid = tv; trig_cpu = tc; trig_word = tw;
    ack_valid = av;  ack_cpu = ac;  ack_id = ai;
    @(negedge clk);
    trig_valid = 1'b0; ack_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    // R1: flags clear and ready high while in reset
    check("R1 reset pend", pend, '0);
    check("R1 ready", {63'd0, trig_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, V_CPU[i], V_WORD[i], 1'b0, '0, '0);
      check($sformatf("R2/R3-R7/R12 vector %0d", i), pend, V_EXP[i]);
      do_reset();
    end

    // R11: strobe low, word would hit every CPU
    step(1'b0, 2'd0, 32'h000F_0004, 1'b0, '0, '0);
    check("R11 no strobe", pend, '0);

    // R8: set cpu0,cpu1 id 9 then clear only cpu1
    step(1'b1, 2'd0, 32'h0003_0009, 1'b0, '0, '0);
    check("R3 set two rows", pend, 64'h0000_0000_0200_0200);
    step(1'b0, 2'd0, '0, 1'b1, 2'd1, 4'd9);
    check("R8 clear one row", pend, 64'h0000_0000_0000_0200);

    // R8: clear of a different number leaves flag
    step(1'b0, 2'd0, '0, 1'b1, 2'd0, 4'd8);
    check("R8 other id untouched", pend, 64'h0000_0000_0000_0200);

    // R9: trigger and acknowledge same flag same cycle
    step(1'b1, 2'd0, 32'h0200_0009, 1'b1, 2'd0, 4'd9);
    check("R9 set wins", pend, 64'h0000_0000_0000_0200);

    // R10: retrigger while pending, then one acknowledge empties it
    step(1'b1, 2'd0, 32'h0200_0009, 1'b0, '0, '0);
    check("R10 retrigger", pend, 64'h0000_0000_0000_0200);
    step(1'b0, 2'd0, '0, 1'b1, 2'd0, 4'd9);
    check("R10 single ack", pend, '0);

    // R12: flags do not move before the edge
    trig_valid = 1'b1; trig_cpu = 2'd2; trig_word = 32'h0200_0006;
    @(posedge clk);
    #1;
    trig_valid = 1'b0;
    check("R12 after edge", pend, 64'h0000_0040_0000_0000);

    // R1: asynchronous reset empties flags
    rst_n = 1'b0;
    #1;
    check("R1 async clear", pend, '0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule